// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic unit of an 8-bit accumulator processor. Each request names an operation, supplies the two accumulators A and B, a memory or immediate operand of up to 16 bits, the index register X and the current condition flags. One clock later it returns the updated 16-bit D value (A in the high byte, B in the low byte), the updated X value and the new flags H, N, Z, V and C. Most operations work on one accumulator, picked by a select input.

Some operations work on the whole of D: a 16-bit add, subtract and compare. There is also an unsigned 8x8 multiply into D, a sign extension of B into A, a decimal adjust of A after a BCD addition, and an addition of the unsigned B to X. The register file and memory access belong to the surrounding core. For each operation, the block updates only the flags that the operation defines and passes every other flag through unchanged.

Top module: `accu_alu`

## Requirements
- R1: Flags are packed as ccIn/ccOut bit 4 = H, bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. The result appears one clock after opValid is high, with resValid high for that one cycle. resD, resX and ccOut hold while opValid is low. Reset clears resValid, resD, resX and ccOut to zero.
- R2: ADD (code 0) and ADC (code 1) add operand[7:0] to the target accumulator, and ADC also adds the C flag. They set H from the carry out of bit 3, C from the carry out of bit 7, V on signed overflow, and N and Z from the result.
- R3: SUB (2), SBC (3, which also subtracts C) and CMP (4) subtract operand[7:0] from the target. C is the borrow, and N, Z and V are set from the difference. H is left unchanged. CMP leaves D unchanged.
- R4: AND (5), OR (6) and EOR (7) combine the target with operand[7:0]. TST (8) only examines the target and does not write it. All four set N and Z, clear V, and leave C and H unchanged.
- R5: COM (9) inverts the target, sets C and clears V. NEG (10) negates the target, sets V only for 0x80 and sets C for any nonzero input. CLR (11) writes zero, sets Z and clears N, V and C. H is unchanged by all three.
- R6: INC (12) and DEC (13) step the target by one. V is set for the inputs 0x7F and 0x80 respectively. C and H are unchanged.
- R7: ASL (14) and ROL (17) move bit 7 into C and set V to bit 7 XOR bit 6. ASR (15) keeps bit 7. LSR (16) shifts in zero. ROL and ROR (18) shift in the old C. ASR, LSR and ROR move bit 0 into C and leave V unchanged.
- R8: ADDD (19), SUBD (20) and CMPD (21) apply operand[15:0] to D without carry in. They set N, Z, V and C from the 16-bit result and leave H unchanged. CMPD leaves D unchanged.
- R9: MUL (22) writes the unsigned product A*B to D. It sets Z when the product is zero and copies product bit 7 into C. H, N and V are unchanged.
- R10: SEX (23) sets A to 0xFF when B bit 7 is 1 and to 0x00 otherwise. It sets N and Z from the 16-bit D.
- R11: DAA (24) corrects A. It adds 0x06 when H is set or the low nibble exceeds 9. It adds 0x60 when C is set, the high nibble exceeds 9, or the high nibble exceeds 8 while the low nibble exceeds 9. C is set on a high correction or a carry, N and Z come from A, and H and V are unchanged.
- R12: ABX (25) writes X + unsigned B to resX and changes neither D nor any flag. The codes 26 to 31 change nothing.
- R13: selB = 0 makes A the target and selB = 1 makes B the target. The other byte of D is unchanged, and resX equals regX for every operation except ABX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation request strobe |
| opCode | input | 5 | Operation code |
| selB | input | 1 | Target accumulator: 0 = A, 1 = B |
| accA | input | 8 | Accumulator A |
| accB | input | 8 | Accumulator B |
| operand | input | 16 | Memory or immediate operand |
| regX | input | 16 | Index register X |
| ccIn | input | 5 | Current flags {H,N,Z,V,C} |
| resValid | output | 1 | Result valid |
| resD | output | 16 | New D = {A,B} |
| resX | output | 16 | New X |
| ccOut | output | 5 | New flags {H,N,Z,V,C} |

## Verification
The hardest cases to reach are the ones that depend on history: decimal adjust corrections driven by H or C, ADC/SBC/ROL/ROR consuming a carry, and flags that must survive an operation. In a real core these states exist only after a previous add or shift. Because ccIn is a port, the bench drives each flag pattern directly, including H and C patterns chosen to expose the low, high and combined DAA corrections. It also sets flags that an operation must leave alone, so a wrongly updated flag shows up at ccOut.

// File: rtl/accu_alu_pkg.sv
package accu_alu_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int OP_W   = 5;
  localparam int CC_W   = 5;

  // flag positions inside the condition vector
  localparam int FH = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_EOR  = 5'd7,
    OP_TST  = 5'd8,  OP_COM  = 5'd9,  OP_NEG  = 5'd10, OP_CLR  = 5'd11,
    OP_INC  = 5'd12, OP_DEC  = 5'd13, OP_ASL  = 5'd14, OP_ASR  = 5'd15,
    OP_LSR  = 5'd16, OP_ROL  = 5'd17, OP_ROR  = 5'd18, OP_ADDD = 5'd19,
    OP_SUBD = 5'd20, OP_CMPD = 5'd21, OP_MUL  = 5'd22, OP_SEX  = 5'd23,
    OP_DAA  = 5'd24, OP_ABX  = 5'd25
  } aluOp_e;

  typedef enum logic [2:0] {
    DST_NONE = 3'd0,
    DST_TGT  = 3'd1,
    DST_HIGH = 3'd2,
    DST_WORD = 3'd3,
    DST_X    = 3'd4
  } dest_e;

  typedef struct packed {
    dest_e           dest;
    logic            wordFlags;
    logic            useCarry;
    logic [CC_W-1:0] updMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/accu_alu_ctrl.sv
module accu_alu_ctrl
  import accu_alu_pkg::*;
(
  input  aluOp_e       op,
  output ctrlStrobes_t strobes
);
  localparam logic [CC_W-1:0] M_ALL  = 5'b11111;
  localparam logic [CC_W-1:0] M_NZVC = 5'b01111;
  localparam logic [CC_W-1:0] M_NZV  = 5'b01110;
  localparam logic [CC_W-1:0] M_NZC  = 5'b01101;
  localparam logic [CC_W-1:0] M_NZ   = 5'b01100;
  localparam logic [CC_W-1:0] M_ZC   = 5'b00101;

  always_comb begin
    strobes.dest      = DST_NONE;
    strobes.wordFlags = 1'b0;
    strobes.useCarry  = 1'b0;
    strobes.updMask   = '0;
    case (op)
      OP_ADD: begin strobes.dest = DST_TGT; strobes.updMask = M_ALL; end
      OP_ADC: begin strobes.dest = DST_TGT; strobes.updMask = M_ALL; strobes.useCarry = 1'b1; end
      OP_SUB: begin strobes.dest = DST_TGT; strobes.updMask = M_NZVC; end
      OP_SBC: begin strobes.dest = DST_TGT; strobes.updMask = M_NZVC; strobes.useCarry = 1'b1; end
      OP_CMP: strobes.updMask = M_NZVC;
      OP_AND, OP_OR, OP_EOR: begin strobes.dest = DST_TGT; strobes.updMask = M_NZV; end
      OP_TST: strobes.updMask = M_NZV;
      OP_COM, OP_NEG, OP_CLR: begin strobes.dest = DST_TGT; strobes.updMask = M_NZVC; end
      OP_INC, OP_DEC: begin strobes.dest = DST_TGT; strobes.updMask = M_NZV; end
      OP_ASL, OP_ROL: begin strobes.dest = DST_TGT; strobes.updMask = M_NZVC; end
      OP_ASR, OP_LSR, OP_ROR: begin strobes.dest = DST_TGT; strobes.updMask = M_NZC; end
      OP_ADDD, OP_SUBD: begin
        strobes.dest = DST_WORD; strobes.updMask = M_NZVC; strobes.wordFlags = 1'b1;
      end
      OP_CMPD: begin strobes.updMask = M_NZVC; strobes.wordFlags = 1'b1; end
      OP_MUL: begin strobes.dest = DST_WORD; strobes.updMask = M_ZC; strobes.wordFlags = 1'b1; end
      OP_SEX: begin strobes.dest = DST_WORD; strobes.updMask = M_NZ; strobes.wordFlags = 1'b1; end
      OP_DAA: begin strobes.dest = DST_HIGH; strobes.updMask = M_NZC; end
      OP_ABX: strobes.dest = DST_X;
      default: ;
    endcase
  end
endmodule

// File: rtl/accu_alu_dp.sv
module accu_alu_dp
  import accu_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  aluOp_e            op,
  input  ctrlStrobes_t      strobes,
  input  logic              selB,
  input  logic [BYTE_W-1:0] accA,
  input  logic [BYTE_W-1:0] accB,
  input  logic [WORD_W-1:0] operand,
  input  logic [WORD_W-1:0] regX,
  input  logic [CC_W-1:0]   ccIn,
  output logic              resValid,
  output logic [WORD_W-1:0] resD,
  output logic [WORD_W-1:0] resX,
  output logic [CC_W-1:0]   ccOut
);
  localparam int MSB  = BYTE_W - 1;
  localparam int WMSB = WORD_W - 1;
  localparam logic [BYTE_W-1:0] ONE8    = BYTE_W'(1);
  localparam logic [BYTE_W-1:0] POS_MAX = {1'b0, {(BYTE_W-1){1'b1}}};
  localparam logic [BYTE_W-1:0] NEG_MAX = {1'b1, {(BYTE_W-1){1'b0}}};
  localparam logic [NIB_W-1:0]  NINE    = NIB_W'(9);
  localparam logic [NIB_W-1:0]  EIGHT   = NIB_W'(8);
  localparam logic [NIB_W-1:0]  SIX     = NIB_W'(6);

  logic [BYTE_W-1:0] tgt, m8, byteRes;
  logic [WORD_W-1:0] dVal, wordRes, xRes, dNext, xNext;
  logic              cIn;
  logic [BYTE_W:0]   add9, sub9, daaSum;
  logic [NIB_W:0]    addNib;
  logic [WORD_W:0]   add17, sub17;
  logic              loFix, hiFix;
  logic              hC, nC, zC, vC, cC;
  logic [CC_W-1:0]   cand, ccNext;

  assign tgt  = selB ? accB : accA;
  assign m8   = operand[MSB:0];
  assign dVal = {accA, accB};
  assign cIn  = strobes.useCarry & ccIn[FC];

  assign add9   = {1'b0, tgt} + {1'b0, m8} + {{BYTE_W{1'b0}}, cIn};
  assign sub9   = {1'b0, tgt} - {1'b0, m8} - {{BYTE_W{1'b0}}, cIn};
  assign addNib = {1'b0, tgt[NIB_W-1:0]} + {1'b0, m8[NIB_W-1:0]} + {{NIB_W{1'b0}}, cIn};
  assign add17  = {1'b0, dVal} + {1'b0, operand};
  assign sub17  = {1'b0, dVal} - {1'b0, operand};

  // decimal correction on A
  assign loFix  = ccIn[FH] || (accA[NIB_W-1:0] > NINE);
  assign hiFix  = ccIn[FC] || (accA[MSB:NIB_W] > NINE) ||
                  ((accA[MSB:NIB_W] > EIGHT) && (accA[NIB_W-1:0] > NINE));
  assign daaSum = {1'b0, accA} + {1'b0, (hiFix ? SIX : {NIB_W{1'b0}}), (loFix ? SIX : {NIB_W{1'b0}})};

  always_comb begin
    byteRes = tgt;
    wordRes = dVal;
    xRes    = regX;
    hC      = 1'b0;
    vC      = 1'b0;
    cC      = ccIn[FC];
    case (op)
      OP_ADD, OP_ADC: begin
        byteRes = add9[MSB:0];
        hC      = addNib[NIB_W];
        vC      = (tgt[MSB] == m8[MSB]) && (add9[MSB] != tgt[MSB]);
        cC      = add9[BYTE_W];
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        byteRes = sub9[MSB:0];
        vC      = (tgt[MSB] != m8[MSB]) && (sub9[MSB] != tgt[MSB]);
        cC      = sub9[BYTE_W];
      end
      OP_AND: byteRes = tgt & m8;
      OP_OR:  byteRes = tgt | m8;
      OP_EOR: byteRes = tgt ^ m8;
      OP_TST: byteRes = tgt;
      OP_COM: begin byteRes = ~tgt; cC = 1'b1; end
      OP_NEG: begin byteRes = (~tgt) + ONE8; vC = (tgt == NEG_MAX); cC = |tgt; end
      OP_CLR: begin byteRes = '0; cC = 1'b0; end
      OP_INC: begin byteRes = tgt + ONE8; vC = (tgt == POS_MAX); end
      OP_DEC: begin byteRes = tgt - ONE8; vC = (tgt == NEG_MAX); end
      OP_ASL: begin byteRes = {tgt[MSB-1:0], 1'b0}; cC = tgt[MSB]; vC = tgt[MSB] ^ tgt[MSB-1]; end
      OP_ASR: begin byteRes = {tgt[MSB], tgt[MSB:1]}; cC = tgt[0]; end
      OP_LSR: begin byteRes = {1'b0, tgt[MSB:1]}; cC = tgt[0]; end
      OP_ROL: begin byteRes = {tgt[MSB-1:0], ccIn[FC]}; cC = tgt[MSB]; vC = tgt[MSB] ^ tgt[MSB-1]; end
      OP_ROR: begin byteRes = {ccIn[FC], tgt[MSB:1]}; cC = tgt[0]; end
      OP_ADDD: begin
        wordRes = add17[WMSB:0];
        vC      = (dVal[WMSB] == operand[WMSB]) && (add17[WMSB] != dVal[WMSB]);
        cC      = add17[WORD_W];
      end
      OP_SUBD, OP_CMPD: begin
        wordRes = sub17[WMSB:0];
        vC      = (dVal[WMSB] != operand[WMSB]) && (sub17[WMSB] != dVal[WMSB]);
        cC      = sub17[WORD_W];
      end
      OP_MUL: begin
        wordRes = {{BYTE_W{1'b0}}, accA} * {{BYTE_W{1'b0}}, accB};
        cC      = wordRes[MSB];
      end
      OP_SEX: wordRes = {{BYTE_W{accB[MSB]}}, accB};
      OP_DAA: begin byteRes = daaSum[MSB:0]; cC = hiFix | daaSum[BYTE_W]; end
      OP_ABX: xRes = regX + {{BYTE_W{1'b0}}, accB};
      default: ;
    endcase
  end

  assign nC = strobes.wordFlags ? wordRes[WMSB] : byteRes[MSB];
  assign zC = strobes.wordFlags ? (wordRes == '0) : (byteRes == '0);

  assign cand[FH] = hC;
  assign cand[FN] = nC;
  assign cand[FZ] = zC;
  assign cand[FV] = vC;
  assign cand[FC] = cC;

  // per-flag merge: update only the flags this operation defines
  for (genvar i = 0; i < CC_W; i++) begin : gFlag
    assign ccNext[i] = strobes.updMask[i] ? cand[i] : ccIn[i];
  end

  always_comb begin
    case (strobes.dest)
      DST_TGT:  dNext = selB ? {accA, byteRes} : {byteRes, accB};
      DST_HIGH: dNext = {byteRes, accB};
      DST_WORD: dNext = wordRes;
      default:  dNext = dVal;
    endcase
    xNext = (strobes.dest == DST_X) ? xRes : regX;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resD     <= '0;
      resX     <= '0;
      ccOut    <= '0;
    end else begin
      resValid <= opValid;
      if (opValid) begin
        resD  <= dNext;
        resX  <= xNext;
        ccOut <= ccNext;
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resValid && $stable(resD) && $stable(ccOut))); // R1
  AST_SUB_KEEPS_H: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (op inside {OP_SUB, OP_SBC, OP_CMP}) |=> ccOut[FH] == $past(ccIn[FH])); // R3
  AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (op inside {OP_CMP, OP_TST, OP_CMPD}) |=> resD == {$past(accA), $past(accB)}); // R4
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    opValid && op == OP_CLR |=> ccOut[FZ] && !ccOut[FN] && !ccOut[FV] && !ccOut[FC]); // R5
  AST_STEP_KEEPS_C: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (op inside {OP_INC, OP_DEC}) |=> ccOut[FC] == $past(ccIn[FC])); // R6
  AST_MUL_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    opValid && op == OP_MUL |=>
      resD == ({{BYTE_W{1'b0}}, $past(accA)} * {{BYTE_W{1'b0}}, $past(accB)})); // R9
  AST_ABX_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    opValid && op == OP_ABX |=> ccOut == $past(ccIn) && resD == {$past(accA), $past(accB)}); // R12
  AST_X_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    opValid && op != OP_ABX |=> resX == $past(regX)); // R13
endmodule

// File: rtl/accu_alu.sv
module accu_alu
  import accu_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic              selB,
  input  logic [BYTE_W-1:0] accA,
  input  logic [BYTE_W-1:0] accB,
  input  logic [WORD_W-1:0] operand,
  input  logic [WORD_W-1:0] regX,
  input  logic [CC_W-1:0]   ccIn,
  output logic              resValid,
  output logic [WORD_W-1:0] resD,
  output logic [WORD_W-1:0] resX,
  output logic [CC_W-1:0]   ccOut
);
  aluOp_e       opE;
  ctrlStrobes_t strobes;

  assign opE = aluOp_e'(opCode);

  accu_alu_ctrl ctrl_i (
    .op      (opE),
    .strobes (strobes)
  );

  accu_alu_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .op       (opE),
    .strobes  (strobes),
    .selB     (selB),
    .accA     (accA),
    .accB     (accB),
    .operand  (operand),
    .regX     (regX),
    .ccIn     (ccIn),
    .resValid (resValid),
    .resD     (resD),
    .resX     (resX),
    .ccOut    (ccOut)
  );
endmodule

// File: tb/accu_alu_tb_top.sv
module accu_alu_tb_top;
  localparam logic [4:0] C_ADD = 5'd0,  C_ADC = 5'd1,  C_SUB = 5'd2,  C_SBC = 5'd3;
  localparam logic [4:0] C_CMP = 5'd4,  C_AND = 5'd5,  C_OR  = 5'd6,  C_EOR = 5'd7;
  localparam logic [4:0] C_TST = 5'd8,  C_COM = 5'd9,  C_NEG = 5'd10, C_CLR = 5'd11;
  localparam logic [4:0] C_INC = 5'd12, C_DEC = 5'd13, C_ASL = 5'd14, C_ASR = 5'd15;
  localparam logic [4:0] C_LSR = 5'd16, C_ROL = 5'd17, C_ROR = 5'd18, C_ADDD = 5'd19;
  localparam logic [4:0] C_SUBD = 5'd20, C_CMPD = 5'd21, C_MUL = 5'd22, C_SEX = 5'd23;
  localparam logic [4:0] C_DAA = 5'd24, C_ABX = 5'd25;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [4:0]  opCode = '0;
  logic        selB = 1'b0;
  logic [7:0]  accA = '0, accB = '0;
  logic [15:0] operand = '0, regX = '0;
  logic [4:0]  ccIn = '0;
  logic        resValid;
  logic [15:0] resD, resX;
  logic [4:0]  ccOut;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  accu_alu dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .selB(selB),
    .accA(accA), .accB(accB), .operand(operand), .regX(regX), .ccIn(ccIn),
    .resValid(resValid), .resD(resD), .resX(resX), .ccOut(ccOut)
  );

  task automatic runOp(input string tag, input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic sel, input logic [15:0] opnd, input logic [15:0] x, input logic [4:0] cc,
                       input logic [15:0] expD, input logic [15:0] expX, input logic [4:0] expCc);
    @(negedge clk);
    opCode = op; accA = a; accB = b; selB = sel; operand = opnd; regX = x; ccIn = cc;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    checks++;
    if (resValid !== 1'b1 || resD !== expD || resX !== expX || ccOut !== expCc) begin
      fails++;
      $display("FAIL %s op=%0d: valid=%b D=%h X=%h cc=%b, expected valid=1 D=%h X=%h cc=%b",
               tag, op, resValid, resD, resX, ccOut, expD, expX, expCc);
    end
  endtask

  task automatic testReset();
    checks++;
    if (resValid !== 1'b0 || resD !== 16'h0 || resX !== 16'h0 || ccOut !== 5'b0) begin
      fails++;
      $display("FAIL R1 reset: valid=%b D=%h X=%h cc=%b, expected 0 0000 0000 00000",
               resValid, resD, resX, ccOut);
    end
  endtask

  task automatic testIdleHold();
    runOp("R1", C_INC, 8'h41, 8'h00, 1'b0, 16'h0, 16'h0, 5'b00000, 16'h4200, 16'h0, 5'b00000);
    accA = 8'hFF; ccIn = 5'b11111;
    @(negedge clk);
    checks++;
    if (resValid !== 1'b0 || resD !== 16'h4200 || ccOut !== 5'b00000) begin
      fails++;
      $display("FAIL R1 hold: valid=%b D=%h cc=%b, expected 0 4200 00000", resValid, resD, ccOut);
    end
  endtask

  task automatic testAdd();
    runOp("R2", C_ADD, 8'h3A, 8'h11, 1'b0, 16'h0048, 16'h0, 5'b00000, 16'h8211, 16'h0, 5'b11010);
    runOp("R2", C_ADC, 8'h00, 8'hFF, 1'b1, 16'h0000, 16'h0, 5'b00001, 16'h0000, 16'h0, 5'b10101);
  endtask

  task automatic testSub();
    runOp("R3", C_SUB, 8'h50, 8'h22, 1'b0, 16'h00B0, 16'h0, 5'b10000, 16'hA022, 16'h0, 5'b11011);
    runOp("R3", C_SBC, 8'h33, 8'h10, 1'b1, 16'h000F, 16'h0, 5'b00001, 16'h3300, 16'h0, 5'b00100);
    runOp("R3", C_CMP, 8'h03, 8'h44, 1'b0, 16'h0007, 16'h0, 5'b00000, 16'h0344, 16'h0, 5'b01001);
  endtask

  task automatic testLogic();
    runOp("R4", C_AND, 8'hF0, 8'hBB, 1'b0, 16'h003C, 16'h0, 5'b00011, 16'h30BB, 16'h0, 5'b00001);
    runOp("R4", C_EOR, 8'h12, 8'h5A, 1'b1, 16'h005A, 16'h0, 5'b10000, 16'h1200, 16'h0, 5'b10100);
    runOp("R4", C_OR,  8'h80, 8'h00, 1'b0, 16'h0001, 16'h0, 5'b00000, 16'h8100, 16'h0, 5'b01000);
    runOp("R4", C_TST, 8'h77, 8'h80, 1'b1, 16'h0000, 16'h0, 5'b00011, 16'h7780, 16'h0, 5'b01001);
  endtask

  task automatic testUnary();
    runOp("R5", C_COM, 8'h0F, 8'h01, 1'b0, 16'h0, 16'h0, 5'b00000, 16'hF001, 16'h0, 5'b01001);
    runOp("R5", C_NEG, 8'h80, 8'h00, 1'b0, 16'h0, 16'h0, 5'b00000, 16'h8000, 16'h0, 5'b01011);
    runOp("R5", C_NEG, 8'h09, 8'h00, 1'b1, 16'h0, 16'h0, 5'b00001, 16'h0900, 16'h0, 5'b00100);
    runOp("R5", C_CLR, 8'hAA, 8'h55, 1'b1, 16'h0, 16'h0, 5'b11011, 16'hAA00, 16'h0, 5'b10100);
  endtask

  task automatic testStep();
    runOp("R6", C_INC, 8'h7F, 8'h00, 1'b0, 16'h0, 16'h0, 5'b00001, 16'h8000, 16'h0, 5'b01011);
    runOp("R6", C_DEC, 8'h01, 8'h80, 1'b1, 16'h0, 16'h0, 5'b00000, 16'h017F, 16'h0, 5'b00010);
    runOp("R6", C_INC, 8'hFF, 8'h03, 1'b0, 16'h0, 16'h0, 5'b00000, 16'h0003, 16'h0, 5'b00100);
  endtask

  task automatic testShift();
    runOp("R7", C_ASL, 8'hC1, 8'h00, 1'b0, 16'h0, 16'h0, 5'b00000, 16'h8200, 16'h0, 5'b01001);
    runOp("R7", C_ASR, 8'h00, 8'h81, 1'b1, 16'h0, 16'h0, 5'b00010, 16'h00C0, 16'h0, 5'b01011);
    runOp("R7", C_LSR, 8'h01, 8'h00, 1'b0, 16'h0, 16'h0, 5'b01010, 16'h0000, 16'h0, 5'b00111);
    runOp("R7", C_ROL, 8'h40, 8'h00, 1'b0, 16'h0, 16'h0, 5'b00001, 16'h8100, 16'h0, 5'b01010);
    runOp("R7", C_ROR, 8'h00, 8'h01, 1'b1, 16'h0, 16'h0, 5'b00001, 16'h0080, 16'h0, 5'b01001);
  endtask

  task automatic testWord();
    runOp("R8", C_ADDD, 8'h7F, 8'hFF, 1'b0, 16'h0001, 16'h0, 5'b10001, 16'h8000, 16'h0, 5'b11010);
    runOp("R8", C_SUBD, 8'h10, 8'h00, 1'b0, 16'h2000, 16'h0, 5'b00000, 16'hF000, 16'h0, 5'b01001);
    runOp("R8", C_CMPD, 8'h12, 8'h34, 1'b0, 16'h1234, 16'h0, 5'b01011, 16'h1234, 16'h0, 5'b00100);
  endtask

  task automatic testMul();
    runOp("R9", C_MUL, 8'hFF, 8'hFF, 1'b0, 16'h0, 16'h0, 5'b01111, 16'hFE01, 16'h0, 5'b01010);
    runOp("R9", C_MUL, 8'h00, 8'h80, 1'b0, 16'h0, 16'h0, 5'b00000, 16'h0000, 16'h0, 5'b00100);
    runOp("R9", C_MUL, 8'h10, 8'h08, 1'b0, 16'h0, 16'h0, 5'b00000, 16'h0080, 16'h0, 5'b00001);
  endtask

  task automatic testSex();
    runOp("R10", C_SEX, 8'h00, 8'h80, 1'b0, 16'h0, 16'h0, 5'b00000, 16'hFF80, 16'h0, 5'b01000);
    runOp("R10", C_SEX, 8'h5A, 8'h00, 1'b0, 16'h0, 16'h0, 5'b01000, 16'h0000, 16'h0, 5'b00100);
  endtask

  task automatic testDaa();
    runOp("R11", C_DAA, 8'h41, 8'hBB, 1'b1, 16'h0, 16'h0, 5'b10000, 16'h47BB, 16'h0, 5'b10000);
    runOp("R11", C_DAA, 8'h9A, 8'h00, 1'b0, 16'h0, 16'h0, 5'b00000, 16'h0000, 16'h0, 5'b00101);
    runOp("R11", C_DAA, 8'h25, 8'h00, 1'b0, 16'h0, 16'h0, 5'b00001, 16'h8500, 16'h0, 5'b01001);
  endtask

  task automatic testAbx();
    runOp("R12", C_ABX, 8'h33, 8'hFF, 1'b0, 16'h0, 16'h10F0, 5'b10101, 16'h33FF, 16'h11EF, 5'b10101);
    runOp("R12", 5'd31, 8'h12, 8'h34, 1'b1, 16'hFFFF, 16'h4321, 5'b01010, 16'h1234, 16'h4321, 5'b01010);
  endtask

  task automatic testSelect();
    runOp("R13", C_ADD, 8'h11, 8'h01, 1'b1, 16'h0001, 16'hBEEF, 5'b00000, 16'h1102, 16'hBEEF, 5'b00000);
    runOp("R13", C_COM, 8'h11, 8'h01, 1'b0, 16'h0000, 16'hBEEF, 5'b00000, 16'hEE01, 16'hBEEF, 5'b01001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    testIdleHold();
    testAdd();
    testSub();
    testLogic();
    testUnary();
    testStep();
    testShift();
    testWord();
    testMul();
    testSex();
    testDaa();
    testAbx();
    testSelect();
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule